// File: doc/BRIEF.md
# Request-Response Latency and Credit Monitor

This block is a synthesizable checker that sits beside a single-bit request line and a single-bit response line sharing one clock. It counts each cycle the request line is high as one request and each cycle the response line is high as one response. Responses retire pending requests oldest first, and every pending request carries its own age counter. A response must come between two and five clock edges after the request it retires, and no more than three requests may be pending at once.

Violations are reported as five error kinds. Each kind has a one-cycle pulse and a sticky flag that holds until reset. The current number of pending requests is also an output. An end-of-test strobe lets the surrounding environment ask whether any request is still unanswered. Typical use is to instantiate the monitor next to a handshake in a larger design, or in an emulation build, and watch the sticky flags.

Top module: `rrc_monitor`

## Requirements
- R1: A request seen high at edge t and answered by a response seen high at edge t+k, with 2 <= k <= 5, raises no error and reduces the pending count by one.
- R2: A response at edge t+1 for the oldest pending request raises the early error (error bit 0) and still retires that request.
- R3: If the oldest pending request, seen at edge t, has no response by edge t+5, the late error (error bit 1) pulses after edge t+5 and that request is dropped from the pending set.
- R4: At most 3 requests are pending. A request arriving when the pending count, less any request retired on the same edge, is already 3 raises the overflow error (error bit 2) and is not queued.
- R5: A request line held high for n consecutive cycles counts as n separate requests.
- R6: Responses retire requests in arrival order. A request and a response on the same edge leave the pending count unchanged, because the response retires the oldest entry before the new one joins. The pending count changes by at most one per edge.
- R7: A response while nothing is pending raises the spurious error (error bit 3) and leaves the pending count unchanged. This applies even if a request arrives on the same edge, and that request is then queued.
- R8: The end-of-test strobe raises the unmatched error (error bit 4) if the pending count just before that edge is nonzero.
- R9: Each error pulse is high for exactly the one cycle after the edge on which its condition held. Its sticky bit sets at the same time and stays set until reset.
- R10: A synchronous active-high reset clears the pending count, all age counters, all pulses and all sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request line; one request per high cycle |
| rsp | input | 1 | Response line; one response per high cycle |
| eot | input | 1 | End-of-test strobe |
| outstanding | output | $clog2(MAX_OUT+1) | Number of pending requests |
| err_pulse | output | 5 | One-cycle error pulses: 0 early, 1 late, 2 overflow, 3 spurious, 4 unmatched |
| err_sticky | output | 5 | Sticky error flags, same bit order |

## Verification
The embedded properties assume that reset is held for at least two edges before it is released, and that req, rsp and eot are known, synchronous values at every edge. The history-based checks rely on those points. The bench drives every input on the falling edge and starts each run with a three-edge reset.

The bench then sweeps all 4096 combinations of request and response patterns over a six-cycle window, with an end-of-test strobe and a drain afterwards. This covers every latency from zero to five, full-queue collisions and spurious responses. A queue of request timestamps in the bench gives the expected pulses and count.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

  localparam int ERR_EARLY = 0;
  localparam int ERR_LATE  = 1;
  localparam int ERR_OVER  = 2;
  localparam int ERR_SPUR  = 3;
  localparam int ERR_UNM   = 4;
  localparam int NUM_ERR   = 5;

  // Saturating increment used by the age trackers.
  function automatic int sat_inc(input int val, input int limit);
    return (val >= limit) ? limit : val + 1;
  endfunction

  // Pending count left after this edge's retirement.
  function automatic int after_retire(input int cnt, input logic retire);
    return cnt - (retire ? 1 : 0);
  endfunction

  // True when a response is too soon for a request of the given age.
  function automatic logic too_early(input int age, input int min_lat);
    return age < min_lat;
  endfunction

  // True when the oldest request has used its last legal edge.
  function automatic logic window_closed(input int age, input int max_lat);
    return age >= max_lat;
  endfunction

endpackage

// File: rtl/rrc_age_queue.sv
module rrc_age_queue #(
  parameter int DEPTH   = 3,
  parameter int MAX_LAT = 5,
  parameter int AW      = 3,
  parameter int CW      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic          push,
  output logic [CW-1:0] count,
  output logic [AW-1:0] head_age
);
  import rrc_pkg::*;

  localparam int AGE_SAT = MAX_LAT + 1;

  logic [AW-1:0] age_q   [DEPTH];
  logic [AW-1:0] age_sh  [DEPTH];
  logic [AW-1:0] age_inc [DEPTH];
  logic [AW-1:0] age_n   [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_mid;
  logic [CW-1:0] cnt_n;

  assign cnt_mid = cnt_q - CW'(pop);
  assign cnt_n   = cnt_mid + CW'(push);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i + 1 < DEPTH) begin : g_mid
      assign age_sh[i] = pop ? age_q[i+1] : age_q[i];
    end else begin : g_last
      assign age_sh[i] = pop ? '0 : age_q[i];
    end
    assign age_inc[i] = AW'(sat_inc(int'(age_sh[i]), AGE_SAT));
    assign age_n[i]   = (push && (cnt_mid == CW'(i))) ? AW'(1) : age_inc[i];

    always_ff @(posedge clk) begin
      if (rst) age_q[i] <= '0;
      else     age_q[i] <= age_n[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

  assign count    = cnt_q;
  assign head_age = age_q[0];

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst) pop |-> cnt_q != '0); // R7
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (rst) push |-> (int'(cnt_q) - int'(pop)) < DEPTH); // R4
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst) int'(cnt_q) <= DEPTH); // R4
  AST_HEAD_AGE: assert property (@(posedge clk) disable iff (rst) (cnt_q != '0) |-> int'(age_q[0]) <= MAX_LAT); // R3

endmodule

// File: rtl/rrc_event_decode.sv
module rrc_event_decode #(
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 5,
  parameter int DEPTH   = 3,
  parameter int AW      = 3,
  parameter int CW      = 2
) (
  input  logic                        req,
  input  logic                        rsp,
  input  logic                        eot,
  input  logic [CW-1:0]               count,
  input  logic [AW-1:0]               head_age,
  output logic                        pop,
  output logic                        push,
  output logic [rrc_pkg::NUM_ERR-1:0] ev
);
  import rrc_pkg::*;

  logic has_pend;
  logic rsp_hit;
  logic tmo;
  logic over;

  always_comb begin
    has_pend = (count != '0);
    rsp_hit  = rsp && has_pend;
    tmo      = has_pend && !rsp && window_closed(int'(head_age), MAX_LAT);
    pop      = rsp_hit || tmo;
    over     = req && (after_retire(int'(count), pop) >= DEPTH);
    push     = req && !over;

    ev            = '0;
    ev[ERR_EARLY] = rsp_hit && too_early(int'(head_age), MIN_LAT);
    ev[ERR_LATE]  = tmo;
    ev[ERR_OVER]  = over;
    ev[ERR_SPUR]  = rsp && !has_pend;
    ev[ERR_UNM]   = eot && has_pend;
  end

endmodule

// File: rtl/rrc_error_flags.sv
module rrc_error_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  output logic [N-1:0] pulse,
  output logic [N-1:0] sticky
);

  logic [N-1:0] pulse_q;
  logic [N-1:0] sticky_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q  <= '0;
      sticky_q <= '0;
    end else begin
      pulse_q  <= ev;
      sticky_q <= sticky_q | ev;
    end
  end

  assign pulse  = pulse_q;
  assign sticky = sticky_q;

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst) ($past(sticky_q) & ~sticky_q) == '0); // R9
  AST_PULSE_FROM_EV: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> pulse_q == $past(ev)); // R9

endmodule

// File: rtl/rrc_monitor.sv
module rrc_monitor #(
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 5,
  parameter int MAX_OUT = 3,
  localparam int AW     = $clog2(MAX_LAT + 2),
  localparam int CW     = $clog2(MAX_OUT + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req,
  input  logic                        rsp,
  input  logic                        eot,
  output logic [CW-1:0]               outstanding,
  output logic [rrc_pkg::NUM_ERR-1:0] err_pulse,
  output logic [rrc_pkg::NUM_ERR-1:0] err_sticky
);
  import rrc_pkg::*;

  // Named internal events shared by the submodules and the assertions.
  logic               q_pop;
  logic               q_push;
  logic [CW-1:0]      q_count;
  logic [AW-1:0]      q_head_age;
  logic [NUM_ERR-1:0] err_ev;

  rrc_age_queue #(
    .DEPTH  (MAX_OUT),
    .MAX_LAT(MAX_LAT),
    .AW     (AW),
    .CW     (CW)
  ) queue_i (
    .clk     (clk),
    .rst     (rst),
    .pop     (q_pop),
    .push    (q_push),
    .count   (q_count),
    .head_age(q_head_age)
  );

  rrc_event_decode #(
    .MIN_LAT(MIN_LAT),
    .MAX_LAT(MAX_LAT),
    .DEPTH  (MAX_OUT),
    .AW     (AW),
    .CW     (CW)
  ) decode_i (
    .req     (req),
    .rsp     (rsp),
    .eot     (eot),
    .count   (q_count),
    .head_age(q_head_age),
    .pop     (q_pop),
    .push    (q_push),
    .ev      (err_ev)
  );

  rrc_error_flags #(
    .N(NUM_ERR)
  ) flags_i (
    .clk   (clk),
    .rst   (rst),
    .ev    (err_ev),
    .pulse (err_pulse),
    .sticky(err_sticky)
  );

  assign outstanding = q_count;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (int'(outstanding) <= int'($past(outstanding)) + 1) && (int'(outstanding) + 1 >= int'($past(outstanding)))); // R6
  AST_SPUR_EMPTY: assert property (@(posedge clk) disable iff (rst) (rsp && !req && outstanding == '0) |=> outstanding == '0); // R7
  AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (rst) (req && rsp && outstanding != '0) |=> outstanding == $past(outstanding)); // R6

endmodule

// File: tb/rrc_monitor_tb.sv
module rrc_monitor_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic       rsp = 1'b0;
  logic       eot = 1'b0;
  logic [1:0] outstanding;
  logic [4:0] err_pulse;
  logic [4:0] err_sticky;

  int checks = 0;
  int errors = 0;
  int mq[$];
  int n = 0;
  logic [4:0] exp_sticky = '0;
  string tag_of[5] = '{"R2 early", "R3 late", "R4 overflow", "R7 spurious", "R8 unmatched"};

  always #2 clk = ~clk;

  rrc_monitor dut_i (
    .clk(clk), .rst(rst), .req(req), .rsp(rsp), .eot(eot),
    .outstanding(outstanding), .err_pulse(err_pulse), .err_sticky(err_sticky)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req = 1'b0; rsp = 1'b0; eot = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mq.delete();
    n = 0;
    exp_sticky = '0;
    chk(outstanding == 2'd0, "R10 count after reset", outstanding, 0);
    chk(err_sticky == 5'd0 && err_pulse == 5'd0, "R10 flags after reset", err_sticky, 0);
  endtask

  // One edge: the bench model predicts, the design is sampled at the next falling edge.
  task automatic cyc(input logic r, input logic s, input logic e);
    logic [4:0] ev;
    bit has, pop, over, tmo;
    int ageh, left;
    req = r; rsp = s; eot = e;
    has  = mq.size() > 0;
    ageh = has ? n - mq[0] : 0;
    ev   = '0;
    tmo  = has && !s && ageh >= 5;
    ev[0] = s && has && ageh < 2;
    ev[1] = tmo;
    ev[3] = s && !has;
    ev[4] = e && has;
    pop  = (s && has) || tmo;
    if (pop) void'(mq.pop_front());
    left = mq.size();
    over = r && left >= 3;
    ev[2] = over;
    if (r && !over) mq.push_back(n);
    n++;
    exp_sticky = exp_sticky | ev;
    @(posedge clk);
    @(negedge clk);
    for (int b = 0; b < 5; b++)
      chk(err_pulse[b] == ev[b], tag_of[b], err_pulse[b], ev[b]);
    chk(int'(outstanding) == mq.size(), "R6 pending count", outstanding, mq.size());
    chk(err_sticky == exp_sticky, "R9 sticky", err_sticky, exp_sticky);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // R1: latencies 2 and 5 give no error.
    cyc(1, 0, 0); cyc(0, 0, 0); cyc(0, 1, 0);
    cyc(1, 0, 0); repeat (4) cyc(0, 0, 0); cyc(0, 1, 0);
    chk(err_sticky == 5'd0, "R1 legal latencies", err_sticky, 0);
    chk(outstanding == 2'd0, "R1 all retired", outstanding, 0);

    // R5: held request counts per cycle.
    do_reset();
    repeat (3) cyc(1, 0, 0);
    chk(outstanding == 2'd3, "R5 held request", outstanding, 3);
    cyc(1, 0, 0);
    chk(err_sticky[2] == 1'b1, "R4 fourth request", err_sticky[2], 1);
    repeat (6) cyc(0, 0, 0);

    // Near-exhaustive sweep: 6-cycle request and response patterns.
    for (int p = 0; p < 4096; p++) begin
      do_reset();
      for (int c = 0; c < 6; c++) cyc(p[c], p[6 + c], 1'b0);
      cyc(1'b0, 1'b0, 1'b1);
      repeat (6) cyc(1'b0, 1'b0, 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule